// File: doc/BRIEF.md
# Jump Counter Control Sequencer

This block steps a small accumulator processor through fetch, decode and execute using a four-bit state counter instead of a full next-state table. In every cycle the counter does exactly one of four things: it returns to zero, takes a target chosen by the two opcode bits, advances by one, or keeps its value. Which of these happens depends only on the current state and the memory wait input. The states are numbered in order along each instruction's straight-line path, so an increment covers every transition that does not branch.

The surrounding datapath owns the registers. This block drives them through single-bit microoperation strobes that are decoded from the state, the wait input, the opcode bits and the accumulator sign. The wait input is expected to be synchronized to `clk` already. The reset input is synchronous and acts as one of the clear terms.

State numbers: 0 start of fetch, 1 to 3 fetch wait steps, 4 decode, 5 to 7 load, 8 and 9 store, 10 to 12 add, 13 branch.

Top module: `jump_seq`

## Requirements
- R1: When `rst` is 1 at a rising edge, `state` is 0 after that edge, whatever the state and the other inputs are. This includes state 4 and the counting states. `pc_zero` equals `rst`.
- R2: States 0, 5, 8 and 10 advance to the next number at every edge.
- R3: States 1 and 3 advance by one when `mem_wait` is 1. When `mem_wait` is 0 they hold.
- R4: States 2, 6 and 11 advance by one when `mem_wait` is 0. When `mem_wait` is 1 they hold.
- R5: State 4 takes its successor from `opcode`: 00 gives 5 (load), 01 gives 8 (store), 10 gives 10 (add) and 11 gives 13 (branch).
- R6: States 7, 12 and 13 go to 0. State 9 goes to 0 when `mem_wait` is 0 and holds when `mem_wait` is 1.
- R7: `ir_to_pc` is 1 only in state 13 with `acc_sign` at 1.
- R8: `pc_to_mar` and `pc_inc` are 1 only in state 0. `ir_load` is 1 only in state 3 with `mem_wait` at 1.
- R9: `mem_req` is 1 in states 1, 2, 6, 8, 9 and 11. `mem_read` is 1 in states 1, 2, 6 and 11. `mbr_drive` is 1 in states 8 and 9. `mbr_capture` is 1 in states 2, 6 and 11 with `mem_wait` at 0. All four are 0 everywhere else.
- R10: `ir_to_mar` is 1 in state 4 for opcodes 00, 01 and 10. `ac_to_mbr` is 1 in state 4 for opcode 01. `ac_load` is 1 in state 7 and `ac_add` is 1 in state 12. All are 0 everywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, a clear term |
| mem_wait | input | 1 | Synchronized memory wait |
| opcode | input | 2 | Instruction register bits 15:14 |
| acc_sign | input | 1 | Accumulator bit 15 |
| state | output | 4 | Current state number |
| pc_zero | output | 1 | Clear program counter |
| pc_inc | output | 1 | Increment program counter |
| pc_to_mar | output | 1 | Program counter to address register |
| ir_to_mar | output | 1 | Instruction address field to address register |
| ir_to_pc | output | 1 | Instruction address field to program counter |
| ir_load | output | 1 | Buffer register to instruction register |
| ac_load | output | 1 | Buffer register to accumulator |
| ac_add | output | 1 | Add buffer register into accumulator |
| ac_to_mbr | output | 1 | Accumulator to buffer register |
| mbr_capture | output | 1 | Memory data into buffer register |
| mbr_drive | output | 1 | Buffer register onto memory data |
| mem_req | output | 1 | Memory request |
| mem_read | output | 1 | Read (1) rather than write |

## Verification
Two next-state actions can be requested in the same cycle: the reset clear together with the decode load in state 4, or the reset clear together with an increment in a counting state. State 9 also raises both its count and clear terms when `mem_wait` is 0. The bench asserts `rst` while the counter is in decode and while it is in counting states, and it runs state 9 with `mem_wait` both low and high. Each case is judged against a behavioural next-state table in which clear wins, then load, then count.

// File: rtl/jump_seq.sv
module jump_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_wait,
  input  logic [1:0] opcode,
  input  logic       acc_sign,
  output logic [3:0] state,
  output logic       pc_zero,
  output logic       pc_inc,
  output logic       pc_to_mar,
  output logic       ir_to_mar,
  output logic       ir_to_pc,
  output logic       ir_load,
  output logic       ac_load,
  output logic       ac_add,
  output logic       ac_to_mbr,
  output logic       mbr_capture,
  output logic       mbr_drive,
  output logic       mem_req,
  output logic       mem_read
);

  logic [3:0]  cnt_q;
  logic [15:0] st;
  logic        do_clr, do_ld, do_cnt;
  logic [3:0]  jump_tgt;

  assign st = 16'd1 << cnt_q;

  always_comb begin
    case (opcode)
      2'b00:   jump_tgt = 4'd5;
      2'b01:   jump_tgt = 4'd8;
      2'b10:   jump_tgt = 4'd10;
      default: jump_tgt = 4'd13;
    endcase
  end

  assign do_clr = rst | st[7] | st[12] | st[13] | (st[9] & ~mem_wait);
  assign do_ld  = st[4];
  assign do_cnt = st[0] | st[5] | st[8] | st[10]
                | (mem_wait & (st[1] | st[3]))
                | (~mem_wait & (st[2] | st[6] | st[9] | st[11]));

  always_ff @(posedge clk) begin
    if (do_clr)      cnt_q <= 4'd0;
    else if (do_ld)  cnt_q <= jump_tgt;
    else if (do_cnt) cnt_q <= cnt_q + 4'd1;
  end

  assign state       = cnt_q;
  assign pc_zero     = rst;
  assign pc_inc      = st[0];
  assign pc_to_mar   = st[0];
  assign ir_load     = st[3] & mem_wait;
  assign ir_to_mar   = st[4] & (opcode != 2'b11);
  assign ac_to_mbr   = st[4] & (opcode == 2'b01);
  assign ac_load     = st[7];
  assign ac_add      = st[12];
  assign ir_to_pc    = st[13] & acc_sign;
  assign mem_read    = st[1] | st[2] | st[6] | st[11];
  assign mbr_drive   = st[8] | st[9];
  assign mem_req     = mem_read | mbr_drive;
  assign mbr_capture = ~mem_wait & (st[2] | st[6] | st[11]);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> state == 4'd0); // R1
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd0 || state == 4'd5 || state == 4'd8 || state == 4'd10)
      |=> state == $past(state) + 4'd1); // R2
  AST_WAIT_HIGH_STEP: assert property (@(posedge clk) disable iff (rst)
    ((state == 4'd1 || state == 4'd3) && !mem_wait) |=> $stable(state)); // R3
  AST_WAIT_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
    ((state == 4'd2 || state == 4'd6 || state == 4'd11) && mem_wait) |=> $stable(state)); // R4
  AST_DECODE_JUMP: assert property (@(posedge clk) disable iff (rst)
    state == 4'd4 |=> (state == 4'd5 || state == 4'd8 || state == 4'd10 || state == 4'd13)); // R5
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd7 || state == 4'd12 || state == 4'd13) |=> state == 4'd0); // R6
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ir_to_pc |-> (state == 4'd13 && acc_sign)); // R7
  AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_inc, ir_load, ac_load, ac_add, ir_to_pc})); // R8
  AST_BUS_DIR: assert property (@(posedge clk) disable iff (rst)
    !(mbr_capture && mbr_drive) && !(mem_read && mbr_drive)); // R9
  AST_ADDR_SRC: assert property (@(posedge clk) disable iff (rst)
    !(pc_to_mar && ir_to_mar)); // R10

endmodule

// File: tb/test_jump_seq.sv
module test_jump_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_wait = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic acc_sign = 1'b0;
  logic [3:0] state;
  logic pc_zero, pc_inc, pc_to_mar, ir_to_mar, ir_to_pc, ir_load, ac_load;
  logic ac_add, ac_to_mbr, mbr_capture, mbr_drive, mem_req, mem_read;

  int total = 0;
  int bad = 0;
  int mst = 0;
  string last_tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  jump_seq i_jump_seq (
    .clk(clk), .rst(rst), .mem_wait(mem_wait), .opcode(opcode), .acc_sign(acc_sign),
    .state(state), .pc_zero(pc_zero), .pc_inc(pc_inc), .pc_to_mar(pc_to_mar),
    .ir_to_mar(ir_to_mar), .ir_to_pc(ir_to_pc), .ir_load(ir_load), .ac_load(ac_load),
    .ac_add(ac_add), .ac_to_mbr(ac_to_mbr), .mbr_capture(mbr_capture),
    .mbr_drive(mbr_drive), .mem_req(mem_req), .mem_read(mem_read)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (model state %0d)", tag, what, act, exp, mst);
    end
  endtask

  function automatic int next_of(int s, bit r, bit w, int op);
    if (r) return 0;
    case (s)
      0: return 1;
      1: return w ? 2 : 1;
      2: return w ? 2 : 3;
      3: return w ? 4 : 3;
      4: return (op == 0) ? 5 : (op == 1) ? 8 : (op == 2) ? 10 : 13;
      5: return 6;
      6: return w ? 6 : 7;
      7: return 0;
      8: return 9;
      9: return w ? 9 : 0;
      10: return 11;
      11: return w ? 11 : 12;
      12: return 0;
      13: return 0;
      default: return s;
    endcase
  endfunction

  function automatic string tag_of(int s, bit r);
    if (r) return "R1";
    case (s)
      0, 5, 8, 10: return "R2";
      1, 3: return "R3";
      2, 6, 11: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_outputs();
    bit w = mem_wait;
    chk(last_tag, "state", int'(state), mst);
    chk("R1", "pc_zero", pc_zero, rst);
    chk("R8", "pc_inc", pc_inc, mst == 0);
    chk("R8", "pc_to_mar", pc_to_mar, mst == 0);
    chk("R8", "ir_load", ir_load, mst == 3 && w);
    chk("R7", "ir_to_pc", ir_to_pc, mst == 13 && acc_sign);
    chk("R9", "mem_req", mem_req, mst inside {1, 2, 6, 8, 9, 11});
    chk("R9", "mem_read", mem_read, mst inside {1, 2, 6, 11});
    chk("R9", "mbr_drive", mbr_drive, mst inside {8, 9});
    chk("R9", "mbr_capture", mbr_capture, (mst inside {2, 6, 11}) && !w);
    chk("R10", "ir_to_mar", ir_to_mar, mst == 4 && opcode != 2'b11);
    chk("R10", "ac_to_mbr", ac_to_mbr, mst == 4 && opcode == 2'b01);
    chk("R10", "ac_load", ac_load, mst == 7);
    chk("R10", "ac_add", ac_add, mst == 12);
  endtask

  // drive one cycle: inputs set after negedge, outputs checked, then the edge
  task automatic cyc(bit r, bit w, int op, bit sgn);
    @(negedge clk);
    rst = r; mem_wait = w; opcode = 2'(op); acc_sign = sgn;
    #1;
    compare_outputs();
    @(posedge clk);
    last_tag = tag_of(mst, r);
    mst = next_of(mst, r, w, op);
  endtask

  // run one instruction from state 0 with a given wait length
  task automatic run_instr(int op, bit sgn, int waits);
    int guard = 0;
    do begin
      bit w;
      if (mst inside {1, 3}) w = (guard % (waits + 1)) == waits;
      else if (mst inside {2, 6, 9, 11}) w = (guard % (waits + 1)) != waits;
      else w = guard[0];
      cyc(0, w, op, sgn);
      guard++;
    end while (mst != 0 && guard < 200);
  endtask

  initial begin
    repeat (3) cyc(1, 0, 0, 0);
    // reset state, R1
    @(negedge clk); #1;
    chk("R1", "state after reset", int'(state), 0);
    for (int op = 0; op < 4; op++)
      for (int wl = 0; wl < 3; wl++) run_instr(op, wl[0], wl);
    // branch with sign clear and set, R7
    run_instr(3, 0, 1);
    run_instr(3, 1, 0);
    // reset colliding with decode load, R1 and R5
    for (int op = 0; op < 4; op++) begin
      while (mst != 4) cyc(0, mst inside {1, 3}, op, 0);
      cyc(1, 0, op, 0);
      @(negedge clk); #1;
      chk("R1", "reset over load in decode", int'(state), 0);
    end
    // reset colliding with counting, R1 and R2
    cyc(0, 0, 0, 0);
    cyc(1, 1, 0, 0);
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 0);
    // state 9 both wait levels, R6
    while (mst != 0) cyc(1, 0, 0, 0);
    while (mst != 9) cyc(0, mst inside {1, 3}, 1, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 1, 0);
    // random stimulus
    for (int k = 0; k < 3000; k++)
      cyc(($urandom % 97) == 0, $urandom % 2, $urandom % 4, $urandom % 2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule